// File: doc/BRIEF.md
# Serial Channel Register Block

This block is the processor-side register file of one serial channel. It decodes byte accesses inside a 64-byte window. It holds two mode bytes, which are reached through a pointer that moves forward on its own. It also holds the transmit holding byte and the interrupt mask. It assembles a status byte from its own transmit state and from flags reported by an external receive queue and error logic. Bit timing, baud generation, parity and the receive queue storage live outside. The queue's "data available" and "full" flags and its head byte arrive as inputs. The block answers with a pop strobe and a flush strobe.

A single write to the command offset carries three packed fields. The first is a housekeeping action, the second a transmitter action and the third a receiver action, and all three take effect on the same clock edge. Transmitted bytes leave on a one-byte valid/ready output. The interrupt line is the OR of the interrupt status bits that the mask enables. The receive interrupt source can be switched between "data available" and "queue full".

Top module: `serchan_regs`

## Requirements
- R1: Accesses are decoded from all six address bits. Offset 0x00 is mode, 0x04 is status (writes have no effect), 0x08 is command (write only), 0x0C is receive read / transmit write, 0x14 is interrupt status read / mask write, and 0x18 and 0x1C read the BAUD1 and BAUD2 parameter bytes. Writes to 0x18 and 0x1C have no effect, and every other offset reads 0.
- R2: A read or write at 0x00 reaches mode byte 0 when the pointer is 0 and mode byte 1 when it is 1. Every write at 0x00 sets the pointer to 1, and housekeeping code 1 sets it back to 0.
- R3: A read at 0x0C while rxAvail is high returns rxData and raises rxPop in that cycle. While rxAvail is low the read returns 0 and rxPop stays low.
- R4: The command byte splits into housekeeping [6:4], transmitter [3:2] and receiver [1:0]. For each of the transmitter and receiver fields, 1 enables, 2 disables, and 0 and 3 leave the enable unchanged.
- R5: Housekeeping code 2 (receiver reset) clears rxEnable and raises rxFlush during the command write cycle.
- R6: Housekeeping code 3 (transmitter reset) disables the transmitter, sets transmitter-empty and drops any held byte from txValid.
- R7: Status bit 0 is rxAvail, bit 1 is rxFull, bit 2 (transmitter ready) equals the transmitter enable, bit 3 is transmitter-empty, and bits 7:4 are errFlags[3:0].
- R8: A write at 0x0C stores the byte and clears transmitter-empty. txValid is high exactly while the transmitter is enabled and transmitter-empty is clear, with txData holding the byte. Transmitter-empty is set again only on a cycle where txValid and txReady are both high.
- R9: The three command fields apply in the order housekeeping, transmitter, receiver. A reset plus an enable in one byte leaves that direction enabled.
- R10: Interrupt status bit 0 is the transmitter enable. Bit 1 is rxFull when mode byte 0 bit 6 is set and rxAvail otherwise. Bit 2 is the break-change flag. Bits 7:3 read 0.
- R11: irq is high exactly when the interrupt status AND the mask (bits 7:0) is nonzero.
- R12: A breakEvt pulse sets the break-change flag and housekeeping code 5 clears it. Code 4 raises errClr during the command write cycle. Code 6 raises txBreak and code 7 lowers it.
- R13: After reset the status reads 0x08, the mode bytes, interrupt status and mask are 0, the pointer is 0, and both directions are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset in the window |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the access cycle |
| rxAvail | input | 1 | Receive queue holds at least one byte |
| rxFull | input | 1 | Receive queue is full |
| rxData | input | 8 | Head byte of the receive queue |
| errFlags | input | 4 | Overrun, parity, framing, break (status bits 4..7) |
| breakEvt | input | 1 | Break-change event pulse |
| rxPop | output | 1 | Remove head byte from the queue |
| rxFlush | output | 1 | Empty the receive queue |
| rxEnable | output | 1 | Receiver enabled |
| errClr | output | 1 | Clear external error flags |
| txData | output | 8 | Byte offered for transmission |
| txValid | output | 1 | txData is offered |
| txReady | input | 1 | Consumer takes txData this cycle |
| txBreak | output | 1 | Hold the line in break |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BAUD1 = 0x5A and BAUD2 = 0xC3. These are distinct nonzero patterns, so the sweep over all 64 offsets can tell a baud read apart from an unmapped read or a status read. All sixteen transmitter/receiver field pairs are swept against an arithmetic model of the two enables. The full cross of the three interrupt sources with mask values 0 to 7 brings every AND/OR combination of the interrupt line within reach. The transmitter is checked both with the consumer stalled and with the consumer always ready.

// File: rtl/serchan_pkg.sv
package serchan_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_INT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_BAUD1 = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_BAUD2 = 6'h1C;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_STAT, RD_RX, RD_INT, RD_BAUD1, RD_BAUD2
  } rdSel_t;

  typedef struct packed {
    logic wrMode;
    logic wrTx;
    logic wrImr;
    logic rdRx;
    logic rstPtr;
    logic rstRx;
    logic rstTx;
    logic rstErr;
    logic clrBrk;
    logic brkOn;
    logic brkOff;
    logic txOn;
    logic txOff;
    logic rxOn;
    logic rxOff;
  } strobe_t;
endpackage

// File: rtl/serchan_ctrl.sv
module serchan_ctrl
  import serchan_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb,
  output rdSel_t            rdSel
);
  logic wrAcc, rdAcc, wrCmd;
  logic [2:0] miscCode;
  logic [1:0] txCode, rxCode;

  assign wrAcc    = busSel && busWr;
  assign rdAcc    = busSel && !busWr;
  assign wrCmd    = wrAcc && (busAddr == OFF_CMD);
  assign miscCode = busWdata[6:4];
  assign txCode   = busWdata[3:2];
  assign rxCode   = busWdata[1:0];

  always_comb begin
    stb        = '0;
    stb.wrMode = wrAcc && (busAddr == OFF_MODE);
    stb.wrTx   = wrAcc && (busAddr == OFF_DATA);
    stb.wrImr  = wrAcc && (busAddr == OFF_INT);
    stb.rdRx   = rdAcc && (busAddr == OFF_DATA);
    if (wrCmd) begin
      stb.rstPtr = (miscCode == 3'd1);
      stb.rstRx  = (miscCode == 3'd2);
      stb.rstTx  = (miscCode == 3'd3);
      stb.rstErr = (miscCode == 3'd4);
      stb.clrBrk = (miscCode == 3'd5);
      stb.brkOn  = (miscCode == 3'd6);
      stb.brkOff = (miscCode == 3'd7);
      stb.txOn   = (txCode == 2'd1);
      stb.txOff  = (txCode == 2'd2);
      stb.rxOn   = (rxCode == 2'd1);
      stb.rxOff  = (rxCode == 2'd2);
    end
  end

  always_comb begin
    case (busAddr)
      OFF_MODE:  rdSel = RD_MODE;
      OFF_STAT:  rdSel = RD_STAT;
      OFF_DATA:  rdSel = RD_RX;
      OFF_INT:   rdSel = RD_INT;
      OFF_BAUD1: rdSel = RD_BAUD1;
      OFF_BAUD2: rdSel = RD_BAUD2;
      default:   rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/serchan_dp.sv
module serchan_dp
  import serchan_pkg::*;
#(
  parameter logic [DATA_W-1:0] BAUD1 = 8'h00,
  parameter logic [DATA_W-1:0] BAUD2 = 8'h00,
  parameter int                MODE_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  rdSel_t            rdSel,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxAvail,
  input  logic              rxFull,
  input  logic [DATA_W-1:0] rxData,
  input  logic [3:0]        errFlags,
  input  logic              breakEvt,
  output logic              rxPop,
  output logic              rxFlush,
  output logic              rxEnable,
  output logic              errClr,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txBreak,
  output logic              irq
);
  localparam int PTR_W = (MODE_N > 1) ? $clog2(MODE_N) : 1;

  logic [DATA_W-1:0] modeReg [MODE_N];
  logic [PTR_W-1:0]  modePtr;
  logic [DATA_W-1:0] txHold, imrReg;
  logic              txEn, txEmpty, rxEn, brkChg, brkLine;
  logic [DATA_W-1:0] statByte, isrByte;
  logic              txTaken;

  assign txTaken = txValid && txReady;

  for (genvar g = 0; g < MODE_N; g++) begin : gMode
    always_ff @(posedge clk) begin
      if (!rstN)
        modeReg[g] <= '0;
      else if (stb.wrMode && (modePtr == PTR_W'(g)))
        modeReg[g] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePtr <= '0;
      txHold  <= '0;
      imrReg  <= '0;
      txEn    <= 1'b0;
      txEmpty <= 1'b1;
      rxEn    <= 1'b0;
      brkChg  <= 1'b0;
      brkLine <= 1'b0;
    end else begin
      if (stb.rstPtr) modePtr <= '0;
      else if (stb.wrMode) modePtr <= PTR_W'(MODE_N - 1);
      if (stb.wrImr) imrReg <= busWdata;
      // transmit holding state
      if (txTaken) txEmpty <= 1'b1;
      if (stb.wrTx) begin
        txHold  <= busWdata;
        txEmpty <= 1'b0;
      end
      // command fields: housekeeping, then transmitter, then receiver
      if (stb.rstTx) begin
        txEn    <= 1'b0;
        txEmpty <= 1'b1;
      end
      if (stb.rstRx) rxEn <= 1'b0;
      if (stb.clrBrk) brkChg <= 1'b0;
      if (breakEvt) brkChg <= 1'b1;
      if (stb.brkOn) brkLine <= 1'b1;
      if (stb.brkOff) brkLine <= 1'b0;
      if (stb.txOn) txEn <= 1'b1;
      if (stb.txOff) txEn <= 1'b0;
      if (stb.rxOn) rxEn <= 1'b1;
      if (stb.rxOff) rxEn <= 1'b0;
    end
  end

  assign statByte = {errFlags, txEmpty, txEn, rxFull, rxAvail};
  assign isrByte  = {5'b0, brkChg, (modeReg[0][6] ? rxFull : rxAvail), txEn};

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      case (rdSel)
        RD_MODE:  busRdata = modeReg[modePtr];
        RD_STAT:  busRdata = statByte;
        RD_RX:    busRdata = rxAvail ? rxData : '0;
        RD_INT:   busRdata = isrByte;
        RD_BAUD1: busRdata = BAUD1;
        RD_BAUD2: busRdata = BAUD2;
        default:  busRdata = '0;
      endcase
    end
  end

  assign rxPop    = stb.rdRx && rxAvail;
  assign rxFlush  = stb.rstRx;
  assign errClr   = stb.rstErr;
  assign rxEnable = rxEn;
  assign txData   = txHold;
  assign txValid  = txEn && !txEmpty;
  assign txBreak  = brkLine;
  assign irq      = |(isrByte & imrReg);

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMode |=> (modePtr == PTR_W'(MODE_N - 1))); // R2
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTx && !stb.rstTx |=> !statByte[3]); // R8
  AST_TX_SENT: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && !stb.wrTx |=> !txValid); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !stb.wrTx && !stb.rstTx && !stb.txOff
    |=> txValid && $stable(txData)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (imrReg == '0) |-> !irq); // R11
  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.rstRx && !stb.rxOn |=> !rxEnable); // R5
  AST_TX_RESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.rstTx && !stb.txOn |=> !txValid && !isrByte[0]); // R6
endmodule

// File: rtl/serchan_regs.sv
module serchan_regs
  import serchan_pkg::*;
#(
  parameter logic [7:0] BAUD1 = 8'h00,
  parameter logic [7:0] BAUD2 = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [5:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxAvail,
  input  logic       rxFull,
  input  logic [7:0] rxData,
  input  logic [3:0] errFlags,
  input  logic       breakEvt,
  output logic       rxPop,
  output logic       rxFlush,
  output logic       rxEnable,
  output logic       errClr,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  output logic       txBreak,
  output logic       irq
);
  strobe_t stb;
  rdSel_t  rdSel;

  serchan_ctrl uCtrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb),
    .rdSel    (rdSel)
  );

  serchan_dp #(.BAUD1(BAUD1), .BAUD2(BAUD2), .MODE_N(2)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .busSel   (busSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rxAvail  (rxAvail),
    .rxFull   (rxFull),
    .rxData   (rxData),
    .errFlags (errFlags),
    .breakEvt (breakEvt),
    .rxPop    (rxPop),
    .rxFlush  (rxFlush),
    .rxEnable (rxEnable),
    .errClr   (errClr),
    .txData   (txData),
    .txValid  (txValid),
    .txReady  (txReady),
    .txBreak  (txBreak),
    .irq      (irq)
  );
endmodule

// File: tb/tb_serchan_regs.sv
`timescale 1ns/1ps
module tb_serchan_regs;
  localparam logic [7:0] B1 = 8'h5A;
  localparam logic [7:0] B2 = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWr = 0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic rxAvail = 0, rxFull = 0, breakEvt = 0, txReady = 0;
  logic [7:0] rxData = '0;
  logic [3:0] errFlags = '0;
  logic rxPop, rxFlush, rxEnable, errClr, txValid, txBreak, irq;
  logic [7:0] txData;

  int errors = 0, checks = 0, sentCnt = 0;
  logic [7:0] lastSent = '0;
  logic sawFlush = 0, sawErrClr = 0, sawPop = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  serchan_regs #(.BAUD1(B1), .BAUD2(B2)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxAvail(rxAvail), .rxFull(rxFull),
    .rxData(rxData), .errFlags(errFlags), .breakEvt(breakEvt), .rxPop(rxPop),
    .rxFlush(rxFlush), .rxEnable(rxEnable), .errClr(errClr), .txData(txData),
    .txValid(txValid), .txReady(txReady), .txBreak(txBreak), .irq(irq));

  always @(posedge clk) if (rstN && txValid && txReady) begin
    sentCnt  = sentCnt + 1;
    lastSent = txData;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    #1 sawFlush = rxFlush; sawErrClr = errClr;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata; sawPop = rxPop;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic mTx, mRx;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R13 reset state
    rdReg(6'h04, rd); chk("R13 status", rd, 8'h08);
    rdReg(6'h14, rd); chk("R13 isr", rd, 0);
    rdReg(6'h00, rd); chk("R13 mode0", rd, 0);
    chk("R13 rxEnable", rxEnable, 0);
    chk("R13 irq/txValid", {irq, txValid}, 0);

    // R1 address sweep
    for (int a = 0; a < 64; a++) begin
      logic [7:0] e;
      case (a)
        6'h04: e = 8'h08;
        6'h18: e = B1;
        6'h1C: e = B2;
        default: e = 8'h00;
      endcase
      rdReg(6'(a), rd); chk("R1 sweep", rd, e);
    end
    wr(6'h04, 8'hFF); rdReg(6'h04, rd); chk("R1 status write ignored", rd, 8'h08);
    wr(6'h18, 8'h00); rdReg(6'h18, rd); chk("R1 baud write ignored", rd, B1);

    // R2 mode pointer
    wr(6'h00, 8'h11); rdReg(6'h00, rd); chk("R2 ptr advanced", rd, 8'h00);
    wr(6'h00, 8'h22); rdReg(6'h00, rd); chk("R2 mode1", rd, 8'h22);
    wr(6'h00, 8'h33); rdReg(6'h00, rd); chk("R2 stays on mode1", rd, 8'h33);
    wr(6'h08, 8'h10); rdReg(6'h00, rd); chk("R2 ptr reset", rd, 8'h11);

    // R4 field sweep
    wr(6'h08, 8'h0A); mTx = 0; mRx = 0;
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) begin
        wr(6'h08, 8'((t << 2) | r));
        if (t == 1) mTx = 1; else if (t == 2) mTx = 0;
        if (r == 1) mRx = 1; else if (r == 2) mRx = 0;
        rdReg(6'h04, rd);
        chk("R4 R7 tx enable", rd[2], mTx);
        chk("R4 rx enable", rxEnable, mRx);
      end

    // R9 ordering, R5/R6 resets
    wr(6'h08, 8'h34); rdReg(6'h04, rd); chk("R9 reset+enable tx", rd[2], 1);
    wr(6'h08, 8'h21); chk("R5 flush pulse", sawFlush, 1); chk("R9 reset+enable rx", rxEnable, 1);
    wr(6'h08, 8'h20); chk("R5 rx reset", {sawFlush, rxEnable}, 2'b10);
    wr(6'h08, 8'h01); chk("R5 no flush on plain enable", sawFlush, 0);

    // R8 transmit with stall
    txReady = 0;
    wr(6'h0C, 8'h5A);
    chk("R8 valid", txValid, 1); chk("R8 data", txData, 8'h5A);
    rdReg(6'h04, rd); chk("R8 empty cleared", rd[3], 0);
    repeat (3) @(negedge clk);
    chk("R8 held", {txValid, txData}, {1'b1, 8'h5A});
    chk("R8 no send while stalled", sentCnt, 0);
    txReady = 1;
    @(negedge clk);
    chk("R8 sent", {txValid, 8'(sentCnt), lastSent}, {1'b0, 8'd1, 8'h5A});
    rdReg(6'h04, rd); chk("R8 empty set", rd[3], 1);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = 8'(i * 17) ^ 8'h03;
      wr(6'h0C, b);
      @(negedge clk);
      chk("R8 stream", {8'(sentCnt), lastSent}, {8'(i + 2), b});
    end
    wr(6'h08, 8'h08); wr(6'h0C, 8'hC4);
    chk("R8 disabled holds", txValid, 0);
    rdReg(6'h04, rd); chk("R8 R7 disabled status", rd[3:2], 2'b00);
    wr(6'h08, 8'h04);
    chk("R8 enable releases", {txValid, txData}, {1'b1, 8'hC4});
    @(negedge clk); chk("R8 released sent", lastSent, 8'hC4);
    txReady = 0;
    wr(6'h0C, 8'h99); wr(6'h08, 8'h30);
    chk("R6 drops byte", txValid, 0);
    rdReg(6'h04, rd); chk("R6 status", rd[3:2], 2'b10);

    // R11 irq sweep
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 8; m++) begin
        wr(6'h08, c[0] ? 8'h04 : 8'h08);
        rxAvail = c[1];
        if (c[2]) begin
          @(negedge clk); breakEvt = 1; @(negedge clk); breakEvt = 0;
        end else wr(6'h08, 8'h50);
        wr(6'h14, 8'(m));
        chk("R11 irq", irq, ((c & m) != 0) ? 1 : 0);
      end
    rdReg(6'h14, rd); chk("R10 R12 isr all", rd, 8'h07);
    wr(6'h08, 8'h50); rdReg(6'h14, rd); chk("R12 break clear", rd[2], 0);
    wr(6'h14, 8'h00);

    // R10 receive interrupt source
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 4; v++) begin
        wr(6'h08, 8'h10); wr(6'h00, s ? 8'h40 : 8'h00);
        rxAvail = v[0]; rxFull = v[1];
        rdReg(6'h14, rd);
        chk("R10 rx source", rd[1], s ? v[1] : v[0]);
        rdReg(6'h04, rd);
        chk("R7 rx flags", rd[1:0], v[1:0]);
      end
    rxFull = 0;

    // R3 receive read
    for (int i = 0; i < 4; i++) begin
      rxAvail = 1; rxData = 8'(8'h77 + i * 9);
      rdReg(6'h0C, rd); chk("R3 data", {sawPop, rd}, {1'b1, 8'(8'h77 + i * 9)});
    end
    rxAvail = 0;
    rdReg(6'h0C, rd); chk("R3 empty", {sawPop, rd}, 9'h0);

    // R7 errors, R12 commands
    errFlags = 4'b1010;
    rdReg(6'h04, rd); chk("R7 error bits", rd[7:4], 4'hA);
    wr(6'h08, 8'h40); chk("R12 errClr", sawErrClr, 1);
    wr(6'h08, 8'h60); chk("R12 break on", txBreak, 1);
    wr(6'h08, 8'h70); chk("R12 break off", txBreak, 0);

    finishRun();
  end
endmodule